// File: doc/BRIEF.md
# Dual-Accumulator 8-bit Arithmetic Unit with Condition Flags

This block is the arithmetic slice of a small accumulator machine. It receives the present contents of two 8-bit accumulators (called A and B here), an operand byte and a 4-bit operation code. It produces the values the two accumulators should take after the operation; these outputs are combinational. It also keeps a registered 8-bit condition code byte. The supported operations are:

- add and add-with-carry into A or into B;
- subtract and subtract-with-borrow from A or from B;
- the accumulator-to-accumulator forms A+B into A and A-B into A.

The surrounding datapath writes the accumulator outputs back into its register file. It raises `op_en` in the cycle it commits the operation, and the flag byte then updates on that clock edge. The carry-using forms take their carry or borrow input from the registered C flag. This means a multi-byte add or subtract can be chained one byte per cycle.

Top module: `acc_alu8`

## Requirements
- R1: After a synchronous active-low reset the flag byte `ccr_out` equals the parameter `CCR_RESET` (default 0xD0).
- R2: Flag bit positions are fixed: H is bit 5, N is bit 3, Z is bit 2, V is bit 1 and C is bit 0. Bits 7, 6 and 4 are never changed by any operation.
- R3: Operation codes on `op_sel` are 0 add to A, 1 add to B, 2 add-with-carry to A, 3 add-with-carry to B, 4 subtract from A, 5 subtract from B, 6 subtract-with-borrow from A, 7 subtract-with-borrow from B, 8 A+B into A, 9 A-B into A. The result appears combinationally on the target accumulator output. The other accumulator output equals its input.
- R4: The carry and borrow forms (codes 2, 3, 6, 7) add or subtract the present C flag as the carry/borrow input. All other codes use zero.
- R5: On an add, C is the carry out of bit 7. On a subtract, C is set when the unsigned subtrahend plus the borrow-in exceeds the minuend.
- R6: V is set when the signed (two's-complement) result does not fit in 8 bits.
- R7: Z is set when the 8-bit result is zero. N equals bit 7 of the result.
- R8: On the add codes (0, 1, 2, 3, 8), H is the carry out of bit 3 into bit 4. On the subtract codes, H keeps its previous value.
- R9: Codes 8 and 9 use the B input as the second operand, write A, and pass B through unchanged. The operand byte is ignored by these codes.
- R10: The flag byte changes only on a rising clock edge with `op_en` high. The accumulator outputs follow the inputs whether or not `op_en` is high.
- R11: Codes 10 to 15 pass both accumulators through unchanged and leave every flag unchanged, even with `op_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| op_en | input | 1 | Commit strobe; flags update on this edge |
| op_sel | input | 4 | Operation code (see R3) |
| opnd | input | 8 | Operand byte |
| acc_a_in | input | 8 | Present value of accumulator A |
| acc_b_in | input | 8 | Present value of accumulator B |
| acc_a_out | output | 8 | New value for accumulator A |
| acc_b_out | output | 8 | New value for accumulator B |
| ccr_out | output | 8 | Registered condition code byte |

## Verification
A wrong carry chain shows up as a wrong accumulator output in the same cycle the inputs are applied. A wrong flag is only visible in the cycle after the committing edge. A stale or corrupted C flag is the slowest error to surface. It shows nothing until a later carry or borrow operation, where it appears as a result off by one. For this reason, the stimulus chains carry-using operations directly behind flag-setting ones, so the error appears within two cycles. Held bits, and flags that must not move on disabled or undefined operations, are compared against the byte from the previous cycle.

// File: rtl/acc_alu8_pkg.sv
// Shared definitions for the dual-accumulator arithmetic unit:
// operation codes and the bit positions inside the flag byte.
// Assumes a 4-bit operation code and an 8-bit flag byte.
package acc_alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD_A  = 4'd0,
        OP_ADD_B  = 4'd1,
        OP_ADC_A  = 4'd2,
        OP_ADC_B  = 4'd3,
        OP_SUB_A  = 4'd4,
        OP_SUB_B  = 4'd5,
        OP_SBC_A  = 4'd6,
        OP_SBC_B  = 4'd7,
        OP_AB_ADD = 4'd8,
        OP_AB_SUB = 4'd9
    } alu_op_e;

    localparam int FLG_H = 5;
    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_V = 1;
    localparam int FLG_C = 0;

    typedef struct packed {
        logic valid;     // code is a defined operation
        logic to_b;      // result goes to accumulator B
        logic subtract;  // subtract-type operation
        logic use_carry; // C flag feeds carry/borrow in
        logic src_b;     // second operand is accumulator B
    } alu_ctl_t;

endpackage

// File: rtl/acc_alu8_decode.sv
// Operation decoder: turns the 4-bit code into datapath controls.
// Assumes undefined codes must decode to an invalid, harmless control word.
module acc_alu8_decode
    import acc_alu8_pkg::*;
(
    input  logic [3:0] op_sel,
    output alu_ctl_t   ctl
);

    // Map each operation code onto its control fields.
    always_comb begin
        ctl = '0;
        case (alu_op_e'(op_sel))
            OP_ADD_A:  ctl = '{valid: 1'b1, to_b: 1'b0, subtract: 1'b0, use_carry: 1'b0, src_b: 1'b0};
            OP_ADD_B:  ctl = '{valid: 1'b1, to_b: 1'b1, subtract: 1'b0, use_carry: 1'b0, src_b: 1'b0};
            OP_ADC_A:  ctl = '{valid: 1'b1, to_b: 1'b0, subtract: 1'b0, use_carry: 1'b1, src_b: 1'b0};
            OP_ADC_B:  ctl = '{valid: 1'b1, to_b: 1'b1, subtract: 1'b0, use_carry: 1'b1, src_b: 1'b0};
            OP_SUB_A:  ctl = '{valid: 1'b1, to_b: 1'b0, subtract: 1'b1, use_carry: 1'b0, src_b: 1'b0};
            OP_SUB_B:  ctl = '{valid: 1'b1, to_b: 1'b1, subtract: 1'b1, use_carry: 1'b0, src_b: 1'b0};
            OP_SBC_A:  ctl = '{valid: 1'b1, to_b: 1'b0, subtract: 1'b1, use_carry: 1'b1, src_b: 1'b0};
            OP_SBC_B:  ctl = '{valid: 1'b1, to_b: 1'b1, subtract: 1'b1, use_carry: 1'b1, src_b: 1'b0};
            OP_AB_ADD: ctl = '{valid: 1'b1, to_b: 1'b0, subtract: 1'b0, use_carry: 1'b0, src_b: 1'b1};
            OP_AB_SUB: ctl = '{valid: 1'b1, to_b: 1'b0, subtract: 1'b1, use_carry: 1'b0, src_b: 1'b1};
            default:   ctl = '0;
        endcase
    end

endmodule

// File: rtl/acc_alu8_addsub.sv
// Ripple adder/subtractor with carry, half-carry and overflow outputs.
// Subtraction is done as x + ~y + ~borrow_in; the carry out is inverted
// into a borrow. Assumes DW is even, so that the half carry sits at DW/2.
module acc_alu8_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  logic          cb_in,     // carry in (add) or borrow in (sub)
    input  logic          subtract,
    output logic [DW-1:0] sum,
    output logic          cb_out,    // carry out (add) or borrow out (sub)
    output logic          half_cy,   // carry out of the low half
    output logic          ovf
);

    localparam int HALF = DW / 2;

    logic [DW-1:0] y_eff;
    logic [DW:0]   cy;

    // Invert the second operand and the incoming borrow for subtraction.
    always_comb begin
        y_eff = subtract ? ~y : y;
        cy[0] = subtract ? ~cb_in : cb_in;
    end

    // One full-adder cell per bit position.
    for (genvar i = 0; i < DW; i++) begin : g_cell
        assign sum[i]  = x[i] ^ y_eff[i] ^ cy[i];
        assign cy[i+1] = (x[i] & y_eff[i]) | (cy[i] & (x[i] ^ y_eff[i]));
    end

    // Derive the status bits from the carry chain.
    always_comb begin
        cb_out  = subtract ? ~cy[DW] : cy[DW];
        half_cy = cy[HALF];
        ovf     = cy[DW] ^ cy[DW-1];
    end

endmodule

// File: rtl/acc_alu8_flags.sv
// Condition code register. Updates the arithmetic flags on a committed,
// defined operation. Keeps H on subtracts and never writes bits 7, 6 and 4.
// Assumes a synchronous active-low reset.
module acc_alu8_flags
    import acc_alu8_pkg::*;
#(
    parameter logic [7:0] CCR_RESET = 8'hD0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       commit,
    input  logic       subtract,
    input  logic       res_msb,
    input  logic       res_zero,
    input  logic       cb_out,
    input  logic       half_cy,
    input  logic       ovf,
    output logic [7:0] ccr
);

    // Register the flag byte; only the arithmetic flag bits are ever written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ccr <= CCR_RESET;
        end else if (commit) begin
            if (!subtract) ccr[FLG_H] <= half_cy;
            ccr[FLG_N] <= res_msb;
            ccr[FLG_Z] <= res_zero;
            ccr[FLG_V] <= ovf;
            ccr[FLG_C] <= cb_out;
        end
    end

endmodule

// File: rtl/acc_alu8.sv
// Dual-accumulator arithmetic unit, top level. Decodes the operation,
// selects the operands, runs the add/subtract chain and steers the result
// onto the target accumulator. The flag byte is kept in a register.
// Assumes the caller writes acc_*_out back and strobes op_en to commit.
module acc_alu8
    import acc_alu8_pkg::*;
#(
    parameter int         DW        = 8,
    parameter logic [7:0] CCR_RESET = 8'hD0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_en,
    input  logic [3:0]    op_sel,
    input  logic [DW-1:0] opnd,
    input  logic [DW-1:0] acc_a_in,
    input  logic [DW-1:0] acc_b_in,
    output logic [DW-1:0] acc_a_out,
    output logic [DW-1:0] acc_b_out,
    output logic [7:0]    ccr_out
);

    alu_ctl_t      ctl;
    logic [DW-1:0] lhs;
    logic [DW-1:0] rhs;
    logic          cb_in;
    logic [DW-1:0] res;
    logic          cb_out;
    logic          half_cy;
    logic          ovf;

    acc_alu8_decode u_dec (
        .op_sel (op_sel),
        .ctl    (ctl)
    );

    // Pick the two operands and the carry/borrow input.
    always_comb begin
        lhs   = ctl.to_b ? acc_b_in : acc_a_in;
        rhs   = ctl.src_b ? acc_b_in : opnd;
        cb_in = ctl.use_carry & ccr_out[FLG_C];
    end

    acc_alu8_addsub #(.DW(DW)) u_arith (
        .x        (lhs),
        .y        (rhs),
        .cb_in    (cb_in),
        .subtract (ctl.subtract),
        .sum      (res),
        .cb_out   (cb_out),
        .half_cy  (half_cy),
        .ovf      (ovf)
    );

    // Steer the result to the target accumulator; pass the other through.
    always_comb begin
        acc_a_out = acc_a_in;
        acc_b_out = acc_b_in;
        if (ctl.valid) begin
            if (ctl.to_b) acc_b_out = res;
            else          acc_a_out = res;
        end
    end

    acc_alu8_flags #(.CCR_RESET(CCR_RESET)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (op_en & ctl.valid),
        .subtract (ctl.subtract),
        .res_msb  (res[DW-1]),
        .res_zero (res == '0),
        .cb_out   (cb_out),
        .half_cy  (half_cy),
        .ovf      (ovf),
        .ccr      (ccr_out)
    );

endmodule

// File: rtl/acc_alu8_chk.sv
// Property checker for acc_alu8, attached through bind. It watches the
// ports only and decodes the operation code on its own.
module acc_alu8_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_en,
    input logic [3:0]    op_sel,
    input logic [DW-1:0] acc_a_in,
    input logic [DW-1:0] acc_b_in,
    input logic [DW-1:0] acc_a_out,
    input logic [DW-1:0] acc_b_out,
    input logic [7:0]    ccr_out
);

    logic          is_def;
    logic          tgt_b;
    logic          is_sub;
    logic [DW-1:0] result;

    // Independent view of the code: defined, target and add/subtract class.
    always_comb begin
        is_def = (op_sel <= 4'd9);
        tgt_b  = (op_sel <= 4'd7) && op_sel[0];
        is_sub = (op_sel >= 4'd4 && op_sel <= 4'd7) || (op_sel == 4'd9);
        result = tgt_b ? acc_b_out : acc_a_out;
    end

    // R2
    held_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ccr_out[7:6] == $past(ccr_out[7:6])) && (ccr_out[4] == $past(ccr_out[4])));

    // R10
    no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_en |=> $stable(ccr_out));

    // R11
    undef_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_def |-> (acc_a_out == acc_a_in) && (acc_b_out == acc_b_in));

    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && is_def) |=> ccr_out[2] == ($past(result) == '0));

    // R7
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && is_def) |=> ccr_out[3] == $past(result[DW-1]));

    // R8
    half_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && is_sub) |=> $stable(ccr_out[5]));

    // R3
    other_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_def |-> (tgt_b ? (acc_a_out == acc_a_in) : (acc_b_out == acc_b_in)));

endmodule

bind acc_alu8 acc_alu8_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_en     (op_en),
    .op_sel    (op_sel),
    .acc_a_in  (acc_a_in),
    .acc_b_in  (acc_b_in),
    .acc_a_out (acc_a_out),
    .acc_b_out (acc_b_out),
    .ccr_out   (ccr_out)
);

// File: tb/acc_alu8_bench.sv
// Scoreboard bench for acc_alu8. The driver applies one operation per cycle
// and queues the expected accumulators and flags. The monitor checks the
// accumulators mid-cycle and the flags just after the following edge.
module acc_alu8_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_en = 1'b0;
    logic [3:0] op_sel = 4'd0;
    logic [7:0] opnd = 8'd0;
    logic [7:0] acc_a_in = 8'd0;
    logic [7:0] acc_b_in = 8'd0;
    logic [7:0] acc_a_out;
    logic [7:0] acc_b_out;
    logic [7:0] ccr_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] a_exp;
        logic [7:0] b_exp;
        logic [7:0] f_exp;
        string      tag;
    } item_t;

    item_t      sb_q[$];
    logic [7:0] model_ccr;

    always #10 clk = ~clk;

    acc_alu8 u_acc_alu8 (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_en     (op_en),
        .op_sel    (op_sel),
        .opnd      (opnd),
        .acc_a_in  (acc_a_in),
        .acc_b_in  (acc_b_in),
        .acc_a_out (acc_a_out),
        .acc_b_out (acc_b_out),
        .ccr_out   (ccr_out)
    );

    task automatic check8(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    // Reference model written from the requirements, with integer arithmetic.
    task automatic drive(input logic [3:0] op, input logic [7:0] d, input logic [7:0] a,
                         input logic [7:0] b, input logic en, input string tag);
        item_t it;
        int x, y, ci, sx, sy, r, sr;
        bit sub, tb, def;
        def = (op <= 4'd9);
        tb  = (op <= 4'd7) && op[0];
        sub = (op >= 4'd4 && op <= 4'd7) || op == 4'd9;
        ci  = (op == 4'd2 || op == 4'd3 || op == 4'd6 || op == 4'd7) ? int'(model_ccr[0]) : 0;
        x   = tb ? int'(b) : int'(a);
        y   = (op >= 4'd8) ? int'(b) : int'(d);
        sx  = (x >= 128) ? x - 256 : x;
        sy  = (y >= 128) ? y - 256 : y;
        r   = sub ? x - y - ci : x + y + ci;
        sr  = sub ? sx - sy - ci : sx + sy + ci;
        it.a_exp = a;
        it.b_exp = b;
        it.f_exp = model_ccr;
        it.tag   = tag;
        if (def) begin
            if (tb) it.b_exp = r[7:0];
            else    it.a_exp = r[7:0];
            if (en) begin
                if (!sub) it.f_exp[5] = ((x % 16) + (y % 16) + ci) > 15;
                it.f_exp[3] = r[7];
                it.f_exp[2] = (r[7:0] == 8'd0);
                it.f_exp[1] = (sr > 127) || (sr < -128);
                it.f_exp[0] = sub ? (r < 0) : (r > 255);
            end
        end
        model_ccr = it.f_exp;
        @(negedge clk);
        op_sel   = op;
        opnd     = d;
        acc_a_in = a;
        acc_b_in = b;
        op_en    = en;
        sb_q.push_back(it);
    endtask

    // Monitor: accumulators mid-cycle, flags after the committing edge.
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #5;
            if (sb_q.size() > 0) begin
                it = sb_q[0];
                check8(it.tag, "acc_a_out", acc_a_out, it.a_exp);
                check8(it.tag, "acc_b_out", acc_b_out, it.b_exp);
                @(posedge clk);
                #1;
                check8(it.tag, "ccr_out", ccr_out, it.f_exp);
                void'(sb_q.pop_front());
            end
        end
    end

    // Stimulus sequence.
    initial begin
        logic [7:0] sa, sb, sd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check8("R1", "reset ccr", ccr_out, 8'hD0);
        model_ccr = 8'hD0;

        drive(4'd0, 8'h01, 8'h7F, 8'h33, 1'b1, "R6 add overflow");
        drive(4'd0, 8'h01, 8'hFF, 8'h33, 1'b1, "R5 add carry zero");
        drive(4'd2, 8'h10, 8'h20, 8'h00, 1'b1, "R4 adc uses C");
        drive(4'd3, 8'h0F, 8'h00, 8'h01, 1'b1, "R8 adc B half carry");
        drive(4'd4, 8'h01, 8'h00, 8'h55, 1'b1, "R5 sub borrow");
        drive(4'd6, 8'h00, 8'h10, 8'h55, 1'b1, "R4 sbc uses borrow");
        drive(4'd4, 8'h01, 8'h80, 8'h00, 1'b1, "R6 sub overflow");
        drive(4'd5, 8'h22, 8'h00, 8'h22, 1'b1, "R7 sub B zero");
        drive(4'd7, 8'h01, 8'h00, 8'h00, 1'b1, "R5 sbc B borrow chain");
        drive(4'd8, 8'hEE, 8'h0C, 8'h05, 1'b1, "R9 A plus B");
        drive(4'd9, 8'h00, 8'h05, 8'h0C, 1'b1, "R9 A minus B");
        drive(4'd1, 8'h88, 8'h11, 8'h88, 1'b1, "R3 add B");
        drive(4'd0, 8'h81, 8'h7F, 8'h00, 1'b0, "R10 disabled commit");
        drive(4'd12, 8'hFF, 8'h01, 8'h02, 1'b1, "R11 undefined code");
        drive(4'd15, 8'h00, 8'hAB, 8'hCD, 1'b1, "R11 undefined code");
        drive(4'd0, 8'h08, 8'h08, 8'h00, 1'b1, "R8 add half carry");
        drive(4'd4, 8'h01, 8'h10, 8'h00, 1'b1, "R8 sub keeps H");
        drive(4'd0, 8'hF0, 8'hF0, 8'h00, 1'b1, "R2 flag layout");

        sa = 8'h5A; sb = 8'hC3; sd = 8'h1F;
        for (int k = 0; k < 120; k++) begin
            sa = {sa[6:0], sa[7] ^ sa[5] ^ sa[4] ^ sa[3]};
            sb = sb + 8'h3B;
            sd = sd ^ {sd[0], sa[7:1]};
            drive(4'(k % 11), sd, sa, sb, (k % 7) != 3, "R3 mixed sequence");
        end
        drive(4'd0, 8'h00, 8'h00, 8'h00, 1'b0, "R10 idle");
        repeat (4) @(posedge clk);
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule